// File: doc/BRIEF.md
# Programmable Binary-Tap Interval Timer

A synchronous interval timer built on a free-running binary up-counter. The output is taken from one of four counter stages, picked by a two-bit tap select. Stage N is bit N-1 of the count, so it has a period of 2^N clocks. The timer has two modes. In recycle mode the chosen stage drives the output directly, which gives a square wave at the clock rate divided by 2^N. In single-transition mode the output changes level once, after 2^(N-1) clocks, and a capture latch then holds it there while the counter keeps running.

A polarity input selects between the true output and its complement. Two reset sources clear the counter and the capture latch and stop counting while they are asserted. The first is a master reset. The second is a power-on request, which has effect only while the auto-reset disable input is low. Each new master reset pulse restarts a single-transition interval from zero, so the timer can be retriggered. All control pins are plain levels. The block has no data stream and so no handshake.

Top module: `prog_tap_timer`

## Requirements
- R1: The tap select `tap_sel` picks the counter stage: 2'b00 selects stage 13, 2'b01 selects stage 10, 2'b10 selects stage 8, and 2'b11 selects stage 16. Stage N is bit N-1 of the count.
- R2: While `recycle` is 1, `tick_out` equals bit N-1 of the number of clock edges since reset was released, XORed with `invert`. This is a square wave with a period of 2^N clocks.
- R3: While `recycle` is 0 and `invert` is 0, `tick_out` stays low until 2^(N-1) edges have passed since release. It then goes high and stays high while the counter keeps running, including after the selected bit falls again.
- R4: With `invert` at 1, the output is the complement: it is high after reset and falls when the programmed count is reached.
- R5: While `mst_rst` is 1, the counter is held at zero and `tick_out` equals `invert`. The first edge after `mst_rst` is released counts as edge one, however long reset was held.
- R6: While `auto_off` is 0, `por_req` has the same effect as `mst_rst`.
- R7: While `auto_off` is 1, `por_req` is ignored: counting continues and a held single-transition level is kept.
- R8: A master reset pulse during single-transition mode clears a held level and restarts the interval from zero.
- R9: Setting `recycle` to 1 for at least one clock clears the capture latch. On return to single-transition mode the output rises again only when the selected bit is next high.
- R10: If a reset and the capture of the selected bit fall on the same edge, the reset wins: the output does not change level, and the count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock that is counted |
| mst_rst | input | 1 | Master reset, active high |
| auto_off | input | 1 | High disables the power-on reset path |
| por_req | input | 1 | Power-on reset request pulse |
| tap_sel | input | 2 | Counter stage select |
| recycle | input | 1 | 1 = square-wave mode, 0 = single-transition mode |
| invert | input | 1 | 1 = complemented output |
| tick_out | output | 1 | Timer output |

## Verification
Reset and the capture of the selected stage can land on the same clock edge. A retrigger arriving exactly at the end of an interval produces this collision. The bench provokes it by running stage 8 for 127 edges and then asserting master reset before the 128th edge. The output must stay at its reset level, and the count must start over, so the output rises only after a further full 128 edges.

The mode input clearing the latch and the latch capturing can also coincide. The checker covers that case with a property: after any cycle spent in recycle mode, the latch must be clear.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int TAP_COUNT = 4;
  localparam int TSEL_W    = $clog2(TAP_COUNT);

  typedef enum logic {
    MODE_SINGLE  = 1'b0,
    MODE_RECYCLE = 1'b1
  } run_mode_e;
endpackage

// File: rtl/ptt_counter.sv
module ptt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         hold_clr,
  output logic [W-1:0] count
);
  // Counting is suspended and cleared while any reset is active.
  always_ff @(posedge clk) begin
    if (hold_clr) count <= '0;
    else          count <= count + 1'b1;
  end
endmodule

// File: rtl/ptt_tap_mux.sv
module ptt_tap_mux
  import ptt_pkg::*;
#(
  parameter int W  = 16,
  parameter int S0 = 13,
  parameter int S1 = 10,
  parameter int S2 = 8,
  parameter int S3 = 16
) (
  input  logic [W-1:0]      count,
  input  logic [TSEL_W-1:0] sel,
  output logic              tap
);
  localparam int STAGES [TAP_COUNT] = '{S0, S1, S2, S3};

  logic [TAP_COUNT-1:0] taps;

  // Stage N of a binary ripple corresponds to count bit N-1.
  for (genvar i = 0; i < TAP_COUNT; i++) begin : g_tap
    assign taps[i] = count[STAGES[i]-1];
  end

  assign tap = taps[sel];
endmodule

// File: rtl/ptt_oneshot.sv
module ptt_oneshot (
  input  logic clk,
  input  logic clr,
  input  logic release_hold,
  input  logic tap,
  output logic held
);
  // Set on the first high level of the tap; later toggles are ignored.
  always_ff @(posedge clk) begin
    if (clr || release_hold) held <= 1'b0;
    else if (tap)            held <= 1'b1;
  end
endmodule

// File: rtl/prog_tap_timer.sv
module prog_tap_timer
  import ptt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int STAGE_SEL0 = 13,
  parameter int STAGE_SEL1 = 10,
  parameter int STAGE_SEL2 = 8,
  parameter int STAGE_SEL3 = 16
) (
  input  logic       clk,
  input  logic       mst_rst,
  input  logic       auto_off,
  input  logic       por_req,
  input  logic [1:0] tap_sel,
  input  logic       recycle,
  input  logic       invert,
  output logic       tick_out
);
  logic             clr;
  logic [CNT_W-1:0] count_q;
  logic             tap_bit;
  logic             held_q;
  logic             level;
  run_mode_e        mode;

  assign mode = run_mode_e'(recycle);
  // The power-on request is honoured only while the auto path is enabled.
  assign clr  = mst_rst | (por_req & ~auto_off);

  ptt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .hold_clr (clr),
    .count    (count_q)
  );

  ptt_tap_mux #(
    .W  (CNT_W),
    .S0 (STAGE_SEL0),
    .S1 (STAGE_SEL1),
    .S2 (STAGE_SEL2),
    .S3 (STAGE_SEL3)
  ) u_mux (
    .count (count_q),
    .sel   (tap_sel),
    .tap   (tap_bit)
  );

  ptt_oneshot u_latch (
    .clk          (clk),
    .clr          (clr),
    .release_hold (mode == MODE_RECYCLE),
    .tap          (tap_bit),
    .held         (held_q)
  );

  // The tap is ORed in so the output moves in the very cycle the count arrives.
  always_comb begin
    if (mode == MODE_RECYCLE) level = tap_bit;
    else                      level = tap_bit | held_q;
    tick_out = level ^ invert;
  end
endmodule

// File: rtl/prog_tap_timer_chk.sv
module prog_tap_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         mst_rst,
  input logic         auto_off,
  input logic         por_req,
  input logic         recycle,
  input logic         invert,
  input logic         tick_out,
  input logic [W-1:0] cnt,
  input logic         held
);
  logic clr_c;
  logic seen = 1'b0;

  assign clr_c = mst_rst | (por_req & ~auto_off);

  always_ff @(posedge clk) begin
    if (clr_c) seen <= 1'b1;
  end

  // R5: reset holds the counter at zero
  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!seen)
    clr_c |=> (cnt == '0));

  // R5: output sits at its reset level after a reset edge
  a_r5_reset_level: assert property (@(posedge clk) disable iff (!seen)
    clr_c |=> (tick_out == invert));

  // R2: one count per edge outside reset
  a_r2_count_step: assert property (@(posedge clk) disable iff (!seen)
    !clr_c |=> (cnt == W'($past(cnt) + 1'b1)));

  // R7: power-on request with auto path disabled does not disturb counting
  a_r7_por_ignored: assert property (@(posedge clk) disable iff (!seen)
    (auto_off && por_req && !mst_rst) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R3: a captured level holds in single-transition mode
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!seen)
    (held && !clr_c && !recycle) |=> held);

  // R9: recycle mode releases the capture latch
  a_r9_recycle_clears: assert property (@(posedge clk) disable iff (!seen)
    recycle |=> !held);
endmodule

bind prog_tap_timer prog_tap_timer_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .mst_rst  (mst_rst),
  .auto_off (auto_off),
  .por_req  (por_req),
  .recycle  (recycle),
  .invert   (invert),
  .tick_out (tick_out),
  .cnt      (count_q),
  .held     (held_q)
);

// File: tb/prog_tap_timer_test.sv
`timescale 1ns/1ps
module prog_tap_timer_test;
  logic       clk = 1'b0;
  logic       mst_rst = 1'b1;
  logic       auto_off = 1'b0;
  logic       por_req = 1'b0;
  logic [1:0] tap_sel = 2'b10;
  logic       recycle = 1'b0;
  logic       invert = 1'b0;
  logic       tick_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prog_tap_timer uut (
    .clk      (clk),
    .mst_rst  (mst_rst),
    .auto_off (auto_off),
    .por_req  (por_req),
    .tap_sel  (tap_sel),
    .recycle  (recycle),
    .invert   (invert),
    .tick_out (tick_out)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        rec;
    logic        inv;
    logic [16:0] k;
    logic        exp;
  } vec_t;

  // sel: 00=stage13, 01=stage10, 10=stage8, 11=stage16 (R1)
  localparam vec_t VECS [13] = '{
    '{2'b10, 1'b0, 1'b0, 17'd127,   1'b0},
    '{2'b10, 1'b0, 1'b0, 17'd128,   1'b1},
    '{2'b10, 1'b0, 1'b0, 17'd300,   1'b1},
    '{2'b10, 1'b1, 1'b0, 17'd300,   1'b0},
    '{2'b10, 1'b1, 1'b0, 17'd200,   1'b1},
    '{2'b01, 1'b0, 1'b1, 17'd511,   1'b1},
    '{2'b01, 1'b0, 1'b1, 17'd512,   1'b0},
    '{2'b01, 1'b1, 1'b0, 17'd700,   1'b1},
    '{2'b00, 1'b0, 1'b0, 17'd4095,  1'b0},
    '{2'b00, 1'b0, 1'b0, 17'd4096,  1'b1},
    '{2'b00, 1'b1, 1'b1, 17'd8292,  1'b1},
    '{2'b11, 1'b0, 1'b0, 17'd32767, 1'b0},
    '{2'b11, 1'b0, 1'b0, 17'd32768, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    #1;
    checks++;
    if (tick_out !== exp) begin
      errors++;
      $display("FAIL %s: tick_out=%b expected=%b at %0t", req, tick_out, exp, $time);
    end
  endtask

  // Applies a configuration under master reset, then releases it at a falling edge.
  task automatic restart(input logic [1:0] s, input logic r, input logic v);
    tap_sel = s; recycle = r; invert = v; mst_rst = 1'b1;
    tick(2);
    mst_rst = 1'b0;
  endtask

  initial begin
    tick(1);
    // R5: reset level follows the polarity select
    check("R5", 1'b0);
    invert = 1'b1;
    check("R5", 1'b1);
    invert = 1'b0;

    for (int i = 0; i < 13; i++) begin
      restart(VECS[i].sel, VECS[i].rec, VECS[i].inv);
      tick(int'(VECS[i].k));
      // R1 tap choice; R2 recycle, R3 single true, R4 single inverted
      if (VECS[i].rec)      check("R1/R2", VECS[i].exp);
      else if (VECS[i].inv) check("R1/R4", VECS[i].exp);
      else                  check("R1/R3", VECS[i].exp);
    end

    // R5: a long reset does not advance the count
    tap_sel = 2'b10; recycle = 1'b0; invert = 1'b0; mst_rst = 1'b1;
    tick(40);
    check("R5", 1'b0);
    mst_rst = 1'b0;
    tick(127); check("R5", 1'b0);
    tick(1);   check("R5", 1'b1);

    // R8: retrigger clears the held level and restarts from zero
    mst_rst = 1'b1; tick(1); mst_rst = 1'b0;
    check("R8", 1'b0);
    tick(127); check("R8", 1'b0);
    tick(1);   check("R8", 1'b1);

    // R7: power-on request ignored while disabled (held level kept)
    auto_off = 1'b1; por_req = 1'b1;
    tick(3);
    por_req = 1'b0;
    check("R7", 1'b1);

    // R7: counting continues through an ignored request (recycle, stage 8)
    restart(2'b10, 1'b1, 1'b0);
    tick(100); check("R7", 1'b0);
    por_req = 1'b1; tick(30); por_req = 1'b0;
    check("R7", 1'b1);
    auto_off = 1'b0;

    // R6: power-on request acts as a reset when enabled
    restart(2'b10, 1'b0, 1'b0);
    tick(128); check("R6", 1'b1);
    por_req = 1'b1; tick(2);
    check("R6", 1'b0);
    por_req = 1'b0;
    tick(127); check("R6", 1'b0);
    tick(1);   check("R6", 1'b1);

    // R9: recycle releases the latch; single mode recaptures later
    tick(172);                 // count 300, bit7 low, held high
    check("R9", 1'b1);
    recycle = 1'b1; tick(1);   // count 301
    check("R9", 1'b0);
    recycle = 1'b0;
    check("R9", 1'b0);
    tick(83);                  // count 384, bit7 high
    check("R9", 1'b1);
    tick(128);                 // count 512, bit7 low again
    check("R9", 1'b1);

    // R10: reset on the edge that would capture wins
    restart(2'b10, 1'b0, 1'b0);
    tick(127);
    mst_rst = 1'b1; tick(1);
    check("R10", 1'b0);
    mst_rst = 1'b0;
    tick(127); check("R10", 1'b0);
    tick(1);   check("R10", 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule